// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block sequences the stack traffic of four control-transfer instructions of an 8-bit processor: the software trap, the return from a trap, the subroutine call and the subroutine return. The decode stage pulses `start` with the opcode, the address of that opcode and the current status byte. The sequencer then owns a byte-wide synchronous memory port for the rest of the instruction. It pushes and pulls through a stack that is fixed in page one, fetches the trap vector and reads the call operand. In the final cycle it presents the new program counter, and where the instruction restores status, the new status byte.

The memory is synchronous: read data for an address issued in one cycle arrives in the next. The cycle in which `start` is accepted counts as the first cycle of the instruction, and `done` marks the last. The stack pointer lives in the block and resets to 0xFF.

Top module: `stack_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `sp_out` is 0xFF and neither `mem_re` nor `mem_we` is asserted.
- R2: Opcode 0x00 (trap) takes 7 cycles. It pushes the high byte, then the low byte, of the opcode address plus 2, then the status byte with bit 4 (break) forced to 1.
- R3: The trap then reads 0xFFFE (low) and 0xFFFF (high) into `pc_out`. It asserts `p_we` with `p_out` equal to the entry status with bit 2 (interrupt disable) set and bit 3 (decimal) cleared.
- R4: Opcode 0x40 (trap return) takes 6 cycles. It pulls the status first, then the program counter low byte, then the high byte. It outputs these with `p_we` and `pc_we`.
- R5: Opcode 0x20 (call) takes 6 cycles. It reads the operand at the opcode address plus 1 (low) and plus 2 (high), and pushes the opcode address plus 2, high byte first. It then loads the operand into the program counter.
- R6: Opcode 0x60 (return) takes 6 cycles. It pulls the low byte and then the high byte, and loads their value plus 1 with `p_we` held at 0.
- R7: A push writes 0x0100+SP and then decrements SP. A pull increments SP and then reads 0x0100+SP. SP wraps within 8 bits, so every stack access stays in page one.
- R8: `start` is ignored while `busy` is 1, and any opcode other than the four above is ignored with no bus access and no SP change.
- R9: `done`, `pc_we` and the matching `p_we` are asserted for exactly one cycle, the last one. A read and a write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| opcode | input | 8 | Opcode of the instruction |
| pc_in | input | 16 | Address of the opcode byte |
| p_in | input | 8 | Status byte at instruction entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Load `pc_out` |
| p_out | output | 8 | New status byte |
| p_we | output | 1 | Load `p_out` |
| sp_out | output | 8 | Stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the read |

## Verification
Two things can happen in one cycle here. The capture of a byte read in the previous cycle can coincide with a new bus access that moves the stack pointer. In the call, for example, the operand low byte is latched in the same cycle that the return high byte is pushed. The trap also latches its vector low byte while it issues the high-byte read. The bench provokes these by running call, trap, trap-return and return back to back, including nested ones. It judges the result by the final program counter and stack pointer, and by the bytes found at each stack address in its own memory model. A second `start` issued in mid-sequence must leave the cycle count and results unchanged.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] TRAP_VEC   = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] pc_in,
  input  logic [7:0]  p_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic        pc_we,
  output logic [7:0]  p_out,
  output logic        p_we,
  output logic [7:0]  sp_out,
  output logic [15:0] mem_addr,
  output logic        mem_re,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam logic [2:0] K_IDLE = 3'd0, K_TRAP = 3'd1, K_TRET = 3'd2,
                         K_CALL = 3'd3, K_RET = 3'd4;
  localparam logic [7:0] BRK_BIT = 8'h10, IRQ_OFF = 8'h04, DEC_BIT = 8'h08;

  logic [2:0]  kind, step;
  logic [7:0]  sp, p_r, lo, hi;
  logic [15:0] pc_r;
  logic        pull;

  wire [15:0] ret_addr = pc_r + 16'd2;
  wire [15:0] push_a   = {STACK_PAGE, sp};
  wire [15:0] pull_a   = {STACK_PAGE, sp + 8'd1};

  assign busy   = (kind != K_IDLE);
  assign done   = (kind == K_TRAP) ? (step == 3'd6) : (busy && step == 3'd5);
  assign pc_we  = done;
  assign p_we   = done && (kind == K_TRAP || kind == K_TRET);
  assign sp_out = sp;

  always_comb begin
    pc_out = {mem_rdata, lo};
    p_out  = p_r;
    if (kind == K_RET)  pc_out = {hi, lo} + 16'd1;
    if (kind == K_TRAP) p_out  = (p_r | IRQ_OFF) & ~DEC_BIT;
  end

  always_comb begin
    mem_addr = 16'h0000; mem_re = 1'b0; mem_we = 1'b0; mem_wdata = 8'h00; pull = 1'b0;
    case (kind)
      K_TRAP: case (step)
        3'd1: begin mem_we = 1'b1; mem_addr = push_a; mem_wdata = ret_addr[15:8]; end
        3'd2: begin mem_we = 1'b1; mem_addr = push_a; mem_wdata = ret_addr[7:0]; end
        3'd3: begin mem_we = 1'b1; mem_addr = push_a; mem_wdata = p_r | BRK_BIT; end
        3'd4: begin mem_re = 1'b1; mem_addr = TRAP_VEC; end
        3'd5: begin mem_re = 1'b1; mem_addr = TRAP_VEC + 16'd1; end
        default: ;
      endcase
      K_CALL: case (step)
        3'd1: begin mem_re = 1'b1; mem_addr = pc_r + 16'd1; end
        3'd2: begin mem_we = 1'b1; mem_addr = push_a; mem_wdata = ret_addr[15:8]; end
        3'd3: begin mem_we = 1'b1; mem_addr = push_a; mem_wdata = ret_addr[7:0]; end
        3'd4: begin mem_re = 1'b1; mem_addr = ret_addr; end
        default: ;
      endcase
      K_TRET: if (step >= 3'd2 && step <= 3'd4) begin
        mem_re = 1'b1; mem_addr = pull_a; pull = 1'b1;
      end
      K_RET: if (step == 3'd2 || step == 3'd3) begin
        mem_re = 1'b1; mem_addr = pull_a; pull = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind <= K_IDLE; step <= 3'd0; sp <= 8'hFF;
      p_r <= 8'h00; lo <= 8'h00; hi <= 8'h00; pc_r <= 16'h0000;
    end else begin
      if (!busy) begin
        if (start) begin
          pc_r <= pc_in; p_r <= p_in; step <= 3'd1;
          case (opcode)
            8'h00:   kind <= K_TRAP;
            8'h40:   kind <= K_TRET;
            8'h20:   kind <= K_CALL;
            8'h60:   kind <= K_RET;
            default: step <= 3'd0;
          endcase
        end
      end else if (done) begin
        kind <= K_IDLE; step <= 3'd0;
      end else begin
        step <= step + 3'd1;
      end
      if (mem_we)    sp <= sp - 8'd1;
      else if (pull) sp <= sp + 8'd1;
      if ((kind == K_TRAP && step == 3'd5) || (kind == K_CALL && step == 3'd2) ||
          (kind == K_TRET && step == 3'd4) || (kind == K_RET && step == 3'd3))
        lo <= mem_rdata;
      if (kind == K_RET && step == 3'd4) hi <= mem_rdata;
      if (kind == K_TRET && step == 3'd3) p_r <= mem_rdata;
    end
  end

  p_push_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == $past(sp_out) - 8'd1);
  p_pull_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> sp_out == $past(sp_out) + 8'd1);
  p_stack_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);
  p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_status_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    p_we |-> done);
endmodule

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opcode = 8'h00, p_in = 8'h00, mem_rdata = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic busy, done, pc_we, p_we, mem_re, mem_we;
  logic [15:0] pc_out, mem_addr;
  logic [7:0] p_out, sp_out, mem_wdata;
  logic [7:0] page1 [256];
  int checks = 0, errors = 0, accesses = 0, bad_wr = 0, cyc_seen;
  logic [15:0] got_pc; logic [7:0] got_p; logic got_pwe;

  always #5 clk = ~clk;

  stack_seq u0 (.*);

  always @(posedge clk) begin
    if (mem_we || mem_re) accesses <= accesses + 1;
    if (mem_we) begin
      if (mem_addr[15:8] != 8'h01) bad_wr <= bad_wr + 1;
      page1[mem_addr[7:0]] <= mem_wdata;
    end
    if (mem_re)
      mem_rdata <= (mem_addr[15:8] == 8'h01) ? page1[mem_addr[7:0]]
                                               : (mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A);
    else mem_rdata <= 8'h00;
  end

  initial begin
    #1_000_000;
    errors = errors + 1;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] p, input bit poke);
    @(negedge clk);
    start = 1'b1; opcode = op; pc_in = pc; p_in = p;
    cyc_seen = 1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      cyc_seen = cyc_seen + 1;
      if (done) break;
      if (poke && cyc_seen == 3) begin start = 1'b1; opcode = 8'h60; pc_in = 16'h4444; end
      @(negedge clk);
      start = 1'b0;
    end
    got_pc = pc_out; got_p = p_out; got_pwe = p_we;
    chk("R9 pc_we with done", {31'd0, pc_we}, 32'd1);
    @(negedge clk);
    chk("R9 done single cycle", {30'd0, done, busy}, 32'd0);
  endtask

  // op, pc, p, cycles, expected pc, expected p, expected sp
  localparam logic [71:0] TBL [6] = '{
    {8'h20, 16'h1234, 8'h00, 8'd6, 16'h7E7D, 8'h00, 8'hFD},
    {8'h00, 16'h7E7D, 8'h08, 8'd7, 16'h5A5B, 8'h04, 8'hFA},
    {8'h40, 16'h0000, 8'h00, 8'd6, 16'h7E7F, 8'h18, 8'hFD},
    {8'h60, 16'h0000, 8'h00, 8'd6, 16'h1237, 8'h00, 8'hFF},
    {8'h00, 16'h0000, 8'hFF, 8'd7, 16'h5A5B, 8'hF7, 8'hFC},
    {8'h40, 16'h0000, 8'h00, 8'd6, 16'h0002, 8'hFF, 8'hFF}
  };

  initial begin
    for (int i = 0; i < 256; i++) page1[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idle outputs", {28'd0, busy, done, mem_re, mem_we}, 32'd0);
    chk("R1 sp reset", {24'd0, sp_out}, 32'hFF);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      logic [71:0] e;
      e = TBL[v];
      run(e[71:64], e[63:48], e[47:40], 1'b0);
      chk("R2 R4 R5 R6 cycle count", cyc_seen, {24'd0, e[39:32]});
      chk("R3 R4 R5 R6 new pc", {16'd0, got_pc}, {16'd0, e[31:16]});
      chk("R7 sp after", {24'd0, sp_out}, {24'd0, e[7:0]});
      if (e[71:64] == 8'h00 || e[71:64] == 8'h40) begin
        chk("R3 R4 status load", {31'd0, got_pwe}, 32'd1);
        chk("R3 R4 status value", {24'd0, got_p}, {24'd0, e[15:8]});
      end else
        chk("R5 R6 no status load", {31'd0, got_pwe}, 32'd0);
      if (v == 0) chk("R5 pushed return", {16'd0, page1[8'hFF], page1[8'hFE]}, 32'h1236);
      if (v == 1) chk("R2 pushed frame", {8'd0, page1[8'hFD], page1[8'hFC], page1[8'hFB]}, 32'h7E7F18);
    end

    // R2 R8: trap with a stray start in mid-sequence
    run(8'h00, 16'hABCD, 8'h00, 1'b1);
    chk("R8 cycles with stray start", cyc_seen, 32'd7);
    chk("R2 frame order", {8'd0, page1[8'hFF], page1[8'hFE], page1[8'hFD]}, 32'hABCF10);
    chk("R3 vector pc", {16'd0, got_pc}, 32'h5A5B);
    chk("R3 status", {24'd0, got_p}, 32'h04);
    chk("R7 sp", {24'd0, sp_out}, 32'hFC);
    run(8'h40, 16'h0000, 8'h00, 1'b0);
    chk("R4 restored pc", {16'd0, got_pc}, 32'hABCF);
    chk("R4 restored status keeps break", {24'd0, got_p}, 32'h10);

    // R8: unknown opcode does nothing
    begin
      int a0;
      a0 = accesses;
      @(negedge clk); start = 1'b1; opcode = 8'hEA;
      @(negedge clk); start = 1'b0;
      repeat (8) @(negedge clk);
      chk("R8 unknown busy", {31'd0, busy}, 32'd0);
      chk("R8 unknown no access", accesses - a0, 32'd0);
      chk("R8 unknown sp", {24'd0, sp_out}, 32'hFF);
    end

    // R7: pull wraps from 0xFF into 0x00
    page1[8'h00] = 8'h34; page1[8'h01] = 8'h12;
    run(8'h60, 16'h0000, 8'h00, 1'b0);
    chk("R6 R7 wrapped return pc", {16'd0, got_pc}, 32'h1235);
    chk("R7 wrapped sp", {24'd0, sp_out}, 32'h01);
    chk("R7 writes in page one", bad_wr, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule